// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a memory-mapped watchdog built around a 64-bit up-counter. The count and the 64-bit expiry period are each exposed as a pair of 32-bit registers on a simple register bus. That bus has an address, a write enable, write data, a read strobe and registered read data. A timer-control register and a global-control register must hold specific mode values before the counter will advance.

Software arms the watchdog by writing two magic keys in sequence to the watchdog-control register. The first key takes the block from idle to a pre-armed state, and the second takes it to the armed state. While armed, software services the watchdog with the same two-key pair, which restarts the count from zero. From the first key onward, every configuration register is frozen and only the key field of the control register is accepted.

The block ends in a tripped state, which only a system reset clears, in either of two cases: the count reaches the period while armed, or a wrong key arrives while armed. On entering that state it drives a reset pulse of fixed length and sets a sticky timeout flag. Software clears the flag by writing 1 to it.

Top module: `keywdt`

## Requirements
- R1: After reset, the reset output is low, every readable register reads zero, and the block is idle (unlocked).
- R2: While idle, the registers read back what was written, one cycle after the read strobe. Counter low is at 0x10, counter high at 0x14, period low at 0x18 and period high at 0x1C. The timer-control mode is bits 7:6 at 0x20, the global-control field is bits 3:0 at 0x24, and the control register is at 0x28. Unmapped addresses read zero, and `bus_rdata` is zero in any cycle after no read strobe.
- R3: A control write of key 0xA5C6 (bits 31:16) with the enable bit (bit 14) set moves the block from idle to pre-armed. A following key 0xDA7E moves it to armed and restarts the count from zero. Any other key while pre-armed is ignored.
- R4: In every state other than idle, writes to the counter, period, timer-control and global-control registers, and to the enable bit, leave them unchanged.
- R5: The counter advances by one per cycle only while armed or servicing, and only when timer-control bits 7:6 equal 2, global-control bits 1:0 equal 3 and global-control bits 3:2 equal 2. Otherwise it holds.
- R6: While armed, key 0xA5C6 enters the service state. Repeated 0xA5C6 writes stay in that state, and 0xDA7E then returns to armed with the count restarted from zero. Serviced in time, the block never trips.
- R7: When the count equals the period while armed or servicing, the block trips. The reset output goes high for exactly 4 cycles (PULSE_LEN), starting at the same edge, and the timeout flag (bit 15 of 0x28) is set. Once tripped, the block stays tripped until system reset and ignores all keys.
- R8: While armed, any key other than 0xA5C6 trips the block at once, including 0xDA7E with no 0xA5C6 just before it. While servicing, any key other than the two valid ones does the same.
- R9: While idle, every control write except 0xA5C6 with the enable bit set is ignored, including 0xDA7E, and the block stays unlocked.
- R10: Writing 1 to bit 15 of the control register clears the timeout flag in any state, unless a trip occurs in the same cycle.
- R11: If the count reaches the period in the same cycle as a 0xDA7E service confirmation, the trip wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the strobe |
| wdt_rst_out | output | 1 | Watchdog reset pulse |

## Verification
The hardest case to reach from the ports is a service confirmation that lands in exactly the cycle where the count meets the period. In that cycle the trip has to win over the restart. The bench arms the block with a small period and then counts edges from the arming confirmation. It places the 0xA5C6 and 0xDA7E writes so that the confirmation is captured on the edge where the count equals the period. A behavioural reference model, stepped every clock, cross-checks the reset output and every read so that near misses are caught as well.

// File: rtl/keywdt_pkg.sv
package keywdt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ARM  = 3'd2,
        ST_SVC  = 3'd3,
        ST_TRIP = 3'd4
    } wdg_state_e;

    localparam int OFF_CNT_LO = 'h10;
    localparam int OFF_CNT_HI = 'h14;
    localparam int OFF_PRD_LO = 'h18;
    localparam int OFF_PRD_HI = 'h1C;
    localparam int OFF_TMR    = 'h20;
    localparam int OFF_GLB    = 'h24;
    localparam int OFF_CTL    = 'h28;

    localparam logic [15:0] KEY_OPEN    = 16'hA5C6;
    localparam logic [15:0] KEY_CONFIRM = 16'hDA7E;

    localparam int KEY_LSB  = 16;
    localparam int EN_BIT   = 14;
    localparam int FLAG_BIT = 15;
    localparam int TMR_LSB  = 6;

    localparam logic [1:0] TMR_CONTINUOUS = 2'd2;
    localparam logic [1:0] GLB_WATCHDOG   = 2'd2;

    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic prd_lo;
        logic prd_hi;
        logic tmr;
        logic glb;
        logic ctl;
    } wr_sel_t;

    function automatic logic run_cfg_ok(input logic [1:0] tmr_mode,
                                        input logic [3:0] glb_field);
        return (tmr_mode == TMR_CONTINUOUS) &&
               (glb_field[1:0] == 2'b11) &&
               (glb_field[3:2] == GLB_WATCHDOG);
    endfunction

endpackage

// File: rtl/keywdt_cfg.sv
module keywdt_cfg
    import keywdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  locked,
    input  wr_sel_t               sel,
    input  logic [DATA_W-1:0]     wdata,
    output logic [2*DATA_W-1:0]   prd,
    output logic [1:0]            tmr_mode,
    output logic [3:0]            glb_field,
    output logic                  en,
    output logic                  run_ok
);
    localparam int PRD_W = 2 * DATA_W;

    logic [PRD_W-1:0] prd_q;
    logic [1:0]       tmr_q;
    logic [3:0]       glb_q;
    logic             en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prd_q <= '0;
            tmr_q <= '0;
            glb_q <= '0;
            en_q  <= 1'b0;
        end else if (!locked) begin
            if (sel.prd_lo) prd_q[DATA_W-1:0]     <= wdata;
            if (sel.prd_hi) prd_q[PRD_W-1:DATA_W] <= wdata;
            if (sel.tmr)    tmr_q <= wdata[TMR_LSB+1:TMR_LSB];
            if (sel.glb)    glb_q <= wdata[3:0];
            if (sel.ctl)    en_q  <= wdata[EN_BIT];
        end
    end

    assign prd       = prd_q;
    assign tmr_mode  = tmr_q;
    assign glb_field = glb_q;
    assign en        = en_q;
    assign run_ok    = run_cfg_ok(tmr_q, glb_q);

    // R4: configuration frozen while locked
    p_period_locked_r4: assert property (@(posedge clk) disable iff (rst)
        $past(locked) |-> ($stable(prd_q) && $stable(tmr_q) && $stable(glb_q) && $stable(en_q)));

endmodule

// File: rtl/keywdt_count.sv
module keywdt_count #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_lo,
    input  logic                  wr_hi,
    input  logic [DATA_W-1:0]     wdata,
    input  logic                  advance,
    input  logic                  clear,
    input  logic [2*DATA_W-1:0]   prd,
    output logic [2*DATA_W-1:0]   cnt,
    output logic                  hit
);
    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q;

    assign hit = advance && (cnt_q == prd);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt_q[DATA_W-1:0]     <= wdata;
            if (wr_hi) cnt_q[CNT_W-1:DATA_W] <= wdata;
        end else if (advance && !hit) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt = cnt_q;

    // R6: a restart leaves the count at zero
    p_restart_zero_r6: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));

    // R5: the count holds when not advancing
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear && !wr_lo && !wr_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/keywdt_seq.sv
module keywdt_seq
    import keywdt_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_wr,
    input  logic [15:0] key,
    input  logic        en_req,
    input  logic        flag_clr,
    input  logic        hit,
    output wdg_state_e  state,
    output logic        restart,
    output logic        counting,
    output logic        flag,
    output logic        rst_out
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    wdg_state_e state_q, state_d;
    logic [PW-1:0] pulse_q;
    logic          flag_q;
    logic          trip_evt;

    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        if (hit) begin
            state_d = ST_TRIP;
        end else if (ctl_wr) begin
            case (state_q)
                ST_IDLE: if (key == KEY_OPEN && en_req) state_d = ST_PRE;
                ST_PRE: if (key == KEY_CONFIRM) begin
                    state_d = ST_ARM;
                    restart = 1'b1;
                end
                ST_ARM: state_d = (key == KEY_OPEN) ? ST_SVC : ST_TRIP;
                ST_SVC: begin
                    if (key == KEY_CONFIRM) begin
                        state_d = ST_ARM;
                        restart = 1'b1;
                    end else if (key != KEY_OPEN) begin
                        state_d = ST_TRIP;
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    assign trip_evt = (state_q != ST_TRIP) && (state_d == ST_TRIP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pulse_q <= '0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (trip_evt) begin
                pulse_q <= PW'(PULSE_LEN);
                flag_q  <= 1'b1;
            end else begin
                if (pulse_q != '0) pulse_q <= pulse_q - PW'(1);
                if (ctl_wr && flag_clr) flag_q <= 1'b0;
            end
        end
    end

    assign state    = state_q;
    assign counting = (state_q == ST_ARM) || (state_q == ST_SVC);
    assign flag     = flag_q;
    assign rst_out  = (pulse_q != '0);

    // R7: entering the tripped state raises the reset output and the flag
    p_expire_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_TRIP) |-> (rst_out && flag_q));

    // R7: tripped state is terminal
    p_trip_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRIP) |=> (state_q == ST_TRIP));

    // R3: armed is reached only from pre-armed or service
    p_arm_entry_r3: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ARM) && ($past(state_q) != ST_ARM)) |->
            (($past(state_q) == ST_PRE) || ($past(state_q) == ST_SVC)));

    // R8: a wrong key while armed trips at once
    p_bad_key_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_ARM) && ctl_wr && (key != KEY_OPEN)) |=> (state_q == ST_TRIP));

    // R11: a hit always trips, even against a confirm
    p_hit_wins_r11: assert property (@(posedge clk) disable iff (rst)
        hit |=> (state_q == ST_TRIP));

endmodule

// File: rtl/keywdt.sv
module keywdt
    import keywdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_rst_out
);
    localparam int CNT_W = 2 * DATA_W;

    wr_sel_t          sel;
    wdg_state_e       state;
    logic             locked, restart, counting, flag, hit, en, run_ok;
    logic [CNT_W-1:0] prd, cnt;
    logic [1:0]       tmr_mode;
    logic [3:0]       glb_field;
    logic [DATA_W-1:0] rd_mux, rdata_q;

    always_comb begin
        sel.cnt_lo = bus_we && (bus_addr == ADDR_W'(OFF_CNT_LO));
        sel.cnt_hi = bus_we && (bus_addr == ADDR_W'(OFF_CNT_HI));
        sel.prd_lo = bus_we && (bus_addr == ADDR_W'(OFF_PRD_LO));
        sel.prd_hi = bus_we && (bus_addr == ADDR_W'(OFF_PRD_HI));
        sel.tmr    = bus_we && (bus_addr == ADDR_W'(OFF_TMR));
        sel.glb    = bus_we && (bus_addr == ADDR_W'(OFF_GLB));
        sel.ctl    = bus_we && (bus_addr == ADDR_W'(OFF_CTL));
    end

    assign locked = (state != ST_IDLE);

    keywdt_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk(clk), .rst(rst), .locked(locked), .sel(sel), .wdata(bus_wdata),
        .prd(prd), .tmr_mode(tmr_mode), .glb_field(glb_field), .en(en), .run_ok(run_ok)
    );

    keywdt_count #(.DATA_W(DATA_W)) u_count (
        .clk(clk), .rst(rst),
        .wr_lo(sel.cnt_lo && !locked), .wr_hi(sel.cnt_hi && !locked),
        .wdata(bus_wdata), .advance(counting && run_ok), .clear(restart),
        .prd(prd), .cnt(cnt), .hit(hit)
    );

    keywdt_seq #(.PULSE_LEN(PULSE_LEN)) u_seq (
        .clk(clk), .rst(rst), .ctl_wr(sel.ctl),
        .key(bus_wdata[KEY_LSB+15:KEY_LSB]), .en_req(bus_wdata[EN_BIT]),
        .flag_clr(bus_wdata[FLAG_BIT]), .hit(hit),
        .state(state), .restart(restart), .counting(counting),
        .flag(flag), .rst_out(wdt_rst_out)
    );

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFF_CNT_LO): rd_mux = cnt[DATA_W-1:0];
            ADDR_W'(OFF_CNT_HI): rd_mux = cnt[CNT_W-1:DATA_W];
            ADDR_W'(OFF_PRD_LO): rd_mux = prd[DATA_W-1:0];
            ADDR_W'(OFF_PRD_HI): rd_mux = prd[CNT_W-1:DATA_W];
            ADDR_W'(OFF_TMR):    rd_mux = DATA_W'(tmr_mode) << TMR_LSB;
            ADDR_W'(OFF_GLB):    rd_mux = DATA_W'(glb_field);
            ADDR_W'(OFF_CTL):    rd_mux = (DATA_W'(flag) << FLAG_BIT) | (DATA_W'(en) << EN_BIT);
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata_q <= '0;
        else     rdata_q <= bus_re ? rd_mux : '0;
    end

    assign bus_rdata = rdata_q;

    // R2: read data is zero after a cycle with no strobe
    p_quiet_bus_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_re |=> (bus_rdata == '0));

endmodule

// File: tb/keywdt_test.sv
module keywdt_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rst_out;

    always #5 clk = ~clk;

    keywdt #(.ADDR_W(8), .DATA_W(32), .PULSE_LEN(4)) uut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata), .wdt_rst_out(rst_out)
    );

    int    vectors = 0;
    int    miscompares = 0;
    string phase = "R1";
    bit    cmp_on = 1'b0;

    // behavioural reference model
    int               m_st;      // 0 idle 1 pre 2 armed 3 service 4 tripped
    longint unsigned  m_cnt, m_prd;
    int               m_mode, m_glb, m_en, m_flag, m_pulse;
    logic [31:0]      m_rd;

    always @(posedge clk) begin : model
        logic [31:0] rv;
        bit run, counting, hit, restart;
        int nst;
        logic [15:0] k;
        if (rst) begin
            m_st = 0; m_cnt = 0; m_prd = 0; m_mode = 0; m_glb = 0;
            m_en = 0; m_flag = 0; m_pulse = 0; m_rd = 0;
        end else begin
            rv = 0;
            case (addr)
                8'h10: rv = m_cnt[31:0];
                8'h14: rv = m_cnt[63:32];
                8'h18: rv = m_prd[31:0];
                8'h1C: rv = m_prd[63:32];
                8'h20: rv = 32'(m_mode) * 64;
                8'h24: rv = 32'(m_glb);
                8'h28: rv = 32'(m_flag) * 32768 + 32'(m_en) * 16384;
                default: rv = 0;
            endcase
            m_rd = re ? rv : 32'h0;
            run = (m_mode == 2) && (m_glb == 11);
            counting = (m_st == 2 || m_st == 3) && run;
            hit = counting && (m_cnt == m_prd);
            nst = m_st; restart = 0; k = wdata[31:16];
            if (hit) nst = 4;
            else if (we && addr == 8'h28) begin
                if (m_st == 0 && k == 16'hA5C6 && wdata[14]) nst = 1;
                else if (m_st == 1 && k == 16'hDA7E) begin nst = 2; restart = 1; end
                else if (m_st == 2) nst = (k == 16'hA5C6) ? 3 : 4;
                else if (m_st == 3) begin
                    if (k == 16'hDA7E) begin nst = 2; restart = 1; end
                    else if (k != 16'hA5C6) nst = 4;
                end
            end
            if (restart) m_cnt = 0;
            else if (m_st == 0 && we && (addr == 8'h10 || addr == 8'h14)) begin
                if (addr == 8'h10) m_cnt = {m_cnt[63:32], wdata};
                else m_cnt = {wdata, m_cnt[31:0]};
            end else if (counting && !hit) m_cnt = m_cnt + 1;
            if (m_st == 0 && we) begin
                case (addr)
                    8'h18: m_prd = {m_prd[63:32], wdata};
                    8'h1C: m_prd = {wdata, m_prd[31:0]};
                    8'h20: m_mode = int'(wdata[7:6]);
                    8'h24: m_glb = int'(wdata[3:0]);
                    8'h28: m_en = int'(wdata[14]);
                    default: ;
                endcase
            end
            if (nst == 4 && m_st != 4) begin
                m_flag = 1; m_pulse = 4;
            end else begin
                if (we && addr == 8'h28 && wdata[15]) m_flag = 0;
                if (m_pulse > 0) m_pulse = m_pulse - 1;
            end
            m_st = nst;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            vectors++;
            if (rst_out !== (m_pulse != 0)) begin
                miscompares++;
                $display("FAIL %s rst_out got %0b exp %0b", phase, rst_out, (m_pulse != 0));
            end
            vectors++;
            if (rdata !== m_rd) begin
                miscompares++;
                $display("FAIL %s rdata got %08h exp %08h", phase, rdata, m_rd);
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got %08h exp %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
        check(tag, rdata, exp);
    endtask

    task automatic rd_model(input logic [7:0] a);
        addr = a; re = 1'b1;
        @(negedge clk);
        re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
    endtask

    task automatic setup(input logic [31:0] prd_lo, input logic [31:0] tmr);
        wr(8'h18, prd_lo);
        wr(8'h1C, 32'h0);
        wr(8'h20, tmr);
        wr(8'h24, 32'h0000000B);
    endtask

    task automatic arm();
        wr(8'h28, 32'hA5C6_4000);
        wr(8'h28, 32'hDA7E_4000);
    endtask

    task automatic service();
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hDA7E_0000);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired in phase %s", phase);
        summary();
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        cmp_on = 1'b1;

        phase = "R1";
        check("R1 rst_out", 32'(rst_out), 32'h0);
        rd_check(8'h18, 32'h0, "R1 period lo");
        rd_check(8'h28, 32'h0, "R1 control");

        phase = "R2";
        wr(8'h18, 32'h0000_0005);
        wr(8'h1C, 32'h1234_5678);
        wr(8'h20, 32'h0000_0080);
        wr(8'h24, 32'h0000_000B);
        wr(8'h10, 32'h0000_0007);
        rd_check(8'h18, 32'h0000_0005, "R2 period lo");
        rd_check(8'h1C, 32'h1234_5678, "R2 period hi");
        rd_check(8'h20, 32'h0000_0080, "R2 timer ctl");
        rd_check(8'h24, 32'h0000_000B, "R2 global ctl");
        rd_check(8'h10, 32'h0000_0007, "R2 counter lo");
        rd_check(8'h30, 32'h0, "R2 unmapped");
        wr(8'h1C, 32'h0);

        phase = "R9";
        wr(8'h28, 32'hDA7E_4000);
        wr(8'h18, 32'd20);
        rd_check(8'h18, 32'd20, "R9 unlocked after stray confirm");
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h18, 32'd21);
        rd_check(8'h18, 32'd21, "R9 unlocked after open without enable");
        wr(8'h18, 32'd20);

        phase = "R3";
        wr(8'h28, 32'hA5C6_4000);
        wr(8'h28, 32'h1234_4000);
        wr(8'h18, 32'd3);
        rd_check(8'h18, 32'd20, "R4 period locked in pre-armed");
        wr(8'h28, 32'hDA7E_4000);
        idle(2);
        rd_model(8'h10);
        check("R3 no trip after arm", 32'(rst_out), 32'h0);

        phase = "R6";
        for (int i = 0; i < 4; i++) begin
            idle(12);
            service();
        end
        check("R6 serviced no trip", 32'(rst_out), 32'h0);
        rd_check(8'h28, 32'h0000_4000, "R6 flag clear");

        phase = "R4";
        wr(8'h18, 32'd2);
        wr(8'h24, 32'h0);
        wr(8'h10, 32'hFFFF_0000);
        rd_check(8'h18, 32'd20, "R4 period locked in armed");
        rd_check(8'h24, 32'h0000_000B, "R4 global locked in armed");

        phase = "R7";
        idle(30);
        rd_check(8'h28, 32'h0000_C000, "R7 flag set after expiry");
        wr(8'h28, 32'hA5C6_4000);
        wr(8'h28, 32'hDA7E_4000);
        idle(2);
        check("R7 tripped ignores keys", 32'(rst_out), 32'h0);
        phase = "R10";
        wr(8'h28, 32'h0000_8000);
        rd_check(8'h28, 32'h0000_4000, "R10 flag cleared");

        phase = "R8";
        do_reset();
        setup(32'd100, 32'h80);
        arm();
        idle(3);
        wr(8'h28, 32'hBEEF_0000);
        check("R8 bad key trips", 32'(rst_out), 32'h1);
        idle(6);
        do_reset();
        setup(32'd100, 32'h80);
        arm();
        idle(2);
        wr(8'h28, 32'hDA7E_0000);
        check("R8 lone confirm trips", 32'(rst_out), 32'h1);
        idle(6);

        phase = "R5";
        do_reset();
        setup(32'd3, 32'h40);
        arm();
        idle(10);
        rd_check(8'h10, 32'h0, "R5 counter holds in one-shot mode");
        check("R5 no trip when not running", 32'(rst_out), 32'h0);

        phase = "R11";
        do_reset();
        setup(32'd4, 32'h80);
        arm();
        idle(3);
        wr(8'h28, 32'hA5C6_0000);
        wr(8'h28, 32'hDA7E_0000);
        check("R11 hit beats confirm", 32'(rst_out), 32'h1);
        idle(6);
        rd_check(8'h28, 32'h0000_C000, "R11 flag set");

        idle(2);
        summary();
        $finish;
    end

endmodule